// File: doc/BRIEF.md
# Auto-Baud Serial Port with Receive Queue

This block is a full-duplex asynchronous serial port. Both directions use a fixed frame: one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. Transmit and receive run independently and share one bit-period divisor, counted in system clock cycles. The host can write that divisor directly. The block can also find it by itself: it times the low start bit of an incoming synchronisation character such as 0x55.

Good received bytes go into a first-in first-out queue in the background, so the host can collect them at its own pace. A mode input shrinks the queue to a single holding slot for byte-at-a-time use. The transmit side takes one byte per request through a valid/ready handshake.

The divisor register is wide enough for 160000 cycles per bit. That covers 300 baud from a 48 MHz clock. The floor is kept low enough for 600K baud, which is about 80 cycles per bit.

Top module: `uab_top`

## Requirements
- R1: After reset, `txd` is high and `tx_ready` is high. A byte accepted on `tx_valid` while `tx_ready` is high is sent as a low start bit, the eight data bits (bit 0 first) and a high stop bit. Each bit lasts `baud_div` cycles. `tx_ready` stays low until the stop bit ends.
- R2: A frame on `rxd` with a high stop bit, sampled at mid-bit with `baud_div`, stores its byte in the queue. Bytes leave in arrival order on `rx_data`. `rx_valid` is high while the queue holds anything, and a one-cycle `rx_pop` removes the oldest byte.
- R3: Reception and transmission can overlap in time without corrupting either byte.
- R4: A low pulse on `rxd` that has ended by the midpoint of the start bit is discarded. Nothing is stored and no error is flagged, and the next valid frame is received normally.
- R5: A frame whose stop bit samples low produces a one-cycle `frame_err` pulse, and its byte is not stored.
- R6: With `buf_en` high the queue holds 16 bytes. A byte that arrives while the queue is full is dropped, the earlier 16 are kept, and `rx_overflow` goes high. `rx_overflow` stays high until `ovf_clr` is pulsed.
- R7: With `buf_en` low the queue holds at most one byte. A second byte arriving before the pop is dropped and sets `rx_overflow`.
- R8: The reset value of `baud_div` is 100. A `div_load` pulse loads `div_value` into `baud_div`, raising any value below 8 to 8, and clears `abaud_locked`.
- R9: An `abaud_start` pulse clears `abaud_locked` within one cycle. The next low period on `rxd` is timed in clock cycles from its falling edge to its rising edge. That count becomes `baud_div` and `abaud_locked` goes high. The rest of that synchronisation character is not stored.
- R10: `rx_count` reports the number of stored bytes and is 0 after reset. `rx_pop` on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| tx_valid | input | 1 | Host offers a byte to send |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Transmitter idle, can accept a byte |
| rx_valid | output | 1 | Queue holds at least one byte |
| rx_data | output | 8 | Oldest stored byte |
| rx_pop | input | 1 | Remove the oldest byte |
| rx_count | output | 5 | Number of stored bytes |
| rx_overflow | output | 1 | Sticky: a byte was dropped because the queue was full |
| ovf_clr | input | 1 | Clears `rx_overflow` |
| buf_en | input | 1 | 1 = 16-entry queue, 0 = single holding slot |
| frame_err | output | 1 | One-cycle pulse on a low stop bit |
| div_load | input | 1 | Load `div_value` as the divisor |
| div_value | input | 18 | Divisor to load, in cycles per bit |
| baud_div | output | 18 | Current divisor in cycles per bit |
| abaud_start | input | 1 | Start a divisor measurement |
| abaud_locked | output | 1 | Divisor was set by a completed measurement |

## Verification
The assertions check several properties on every cycle:
- The divisor never falls below its floor.
- The transmit line is high whenever the transmitter is idle, and every frame begins with a low bit.
- A byte is stored only after a high stop-bit sample.
- The queue count never exceeds its depth, a dropped byte leaves the count unchanged, and the overflow flag is sticky.
- A measurement request drops the lock flag at once.

Only the bench scenarios can show the rest: correct bit values and bit order on both lines, the exact divisor found from a timed start bit, rejection of a short glitch, and the order and content of queued bytes across overflow and single-slot mode.

// File: rtl/uab_pkg.sv
`timescale 1ns/1ps
package uab_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        AB_WAIT,
        AB_MEAS,
        AB_SKIP
    } rx_state_e;

    typedef enum logic {
        TX_IDLE,
        TX_SHIFT
    } tx_state_e;
endpackage

// File: rtl/uab_rx.sv
`timescale 1ns/1ps
module uab_rx
    import uab_pkg::*;
#(
    parameter int DIV_W   = 18,
    parameter int MIN_DIV = 8,
    parameter int RST_DIV = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic             div_load,
    input  logic [DIV_W-1:0] div_value,
    input  logic             abaud_start,
    output logic [DIV_W-1:0] baud_div,
    output logic             locked,
    output logic             push,
    output logic [7:0]       push_data,
    output logic             frame_err
);
    localparam logic [DIV_W-1:0] MIN_V   = DIV_W'(MIN_DIV);
    localparam logic [DIV_W-1:0] RST_V   = DIV_W'(RST_DIV);
    localparam logic [DIV_W-1:0] MAX_CNT = '1;

    typedef struct packed {
        rx_state_e        st;
        logic             s1;
        logic             s2;
        logic             prev;
        logic [DIV_W-1:0] cnt;
        logic [3:0]       bits;
        logic [7:0]       sh;
        logic [DIV_W-1:0] div;
        logic             locked;
        logic             push;
        logic             ferr;
    } rx_reg_t;

    rx_reg_t q, d;

    logic             fall_edge;
    logic [DIV_W-1:0] cnt_inc;
    logic [DIV_W-1:0] half_div;

    function automatic logic [DIV_W-1:0] floor_div(input logic [DIV_W-1:0] v);
        return (v < MIN_V) ? MIN_V : v;
    endfunction

    assign fall_edge = q.prev & ~q.s2;
    assign cnt_inc   = (q.cnt == MAX_CNT) ? MAX_CNT : q.cnt + 1'b1;
    assign half_div  = q.div >> 1;

    always_comb begin
        d      = q;
        d.s1   = rxd;
        d.s2   = q.s1;
        d.prev = q.s2;
        d.push = 1'b0;
        d.ferr = 1'b0;
        case (q.st)
            RX_IDLE: begin
                if (fall_edge) begin
                    d.st  = RX_START;
                    d.cnt = 1;
                end
            end
            RX_START: begin
                if (q.cnt >= half_div) begin
                    if (!q.s2) begin
                        d.st   = RX_DATA;
                        d.cnt  = 1;
                        d.bits = '0;
                    end else begin
                        d.st = RX_IDLE;
                    end
                end else begin
                    d.cnt = cnt_inc;
                end
            end
            RX_DATA: begin
                if (q.cnt >= q.div) begin
                    d.sh  = {q.s2, q.sh[7:1]};
                    d.cnt = 1;
                    if (q.bits == 4'd7) d.st = RX_STOP;
                    else                d.bits = q.bits + 4'd1;
                end else begin
                    d.cnt = cnt_inc;
                end
            end
            RX_STOP: begin
                if (q.cnt >= q.div) begin
                    d.st = RX_IDLE;
                    if (q.s2) d.push = 1'b1;
                    else      d.ferr = 1'b1;
                end else begin
                    d.cnt = cnt_inc;
                end
            end
            AB_WAIT: begin
                if (fall_edge) begin
                    d.st  = AB_MEAS;
                    d.cnt = 1;
                end
            end
            AB_MEAS: begin
                if (q.s2) begin
                    d.div    = floor_div(q.cnt);
                    d.locked = 1'b1;
                    d.st     = AB_SKIP;
                    d.cnt    = 1;
                    d.bits   = '0;
                end else begin
                    d.cnt = cnt_inc;
                end
            end
            AB_SKIP: begin
                if (q.bits == 4'd8) begin
                    if (q.cnt >= half_div) d.st = RX_IDLE;
                    else                   d.cnt = cnt_inc;
                end else if (q.cnt >= q.div) begin
                    d.cnt  = 1;
                    d.bits = q.bits + 4'd1;
                end else begin
                    d.cnt = cnt_inc;
                end
            end
            default: d.st = RX_IDLE;
        endcase
        if (abaud_start) begin
            d.st     = AB_WAIT;
            d.locked = 1'b0;
        end else if (div_load) begin
            d.div    = floor_div(div_value);
            d.locked = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= RX_IDLE;
            q.s1     <= 1'b1;
            q.s2     <= 1'b1;
            q.prev   <= 1'b1;
            q.cnt    <= '0;
            q.bits   <= '0;
            q.sh     <= '0;
            q.div    <= RST_V;
            q.locked <= 1'b0;
            q.push   <= 1'b0;
            q.ferr   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign baud_div  = q.div;
    assign locked    = q.locked;
    assign push      = q.push;
    assign push_data = q.sh;
    assign frame_err = q.ferr;

    AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        baud_div >= MIN_V); // R8
    AST_START_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        abaud_start |=> !locked); // R9
    AST_LOCK_FROM_MEASURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.locked) |-> $past(q.st) == AB_MEAS); // R9
    AST_STORE_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        q.push |-> $past(q.s2)); // R5
endmodule

// File: rtl/uab_tx.sv
`timescale 1ns/1ps
module uab_tx
    import uab_pkg::*;
#(
    parameter int DIV_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             txd
);
    localparam int FRAME_BITS = 10;

    typedef struct packed {
        tx_state_e           st;
        logic [FRAME_BITS-1:0] sh;
        logic [DIV_W-1:0]    cnt;
        logic [3:0]          bits;
    } tx_reg_t;

    tx_reg_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            TX_IDLE: begin
                if (tx_valid) begin
                    d.st   = TX_SHIFT;
                    d.sh   = {1'b1, tx_data, 1'b0};
                    d.cnt  = 1;
                    d.bits = '0;
                end
            end
            TX_SHIFT: begin
                if (q.cnt >= baud_div) begin
                    d.cnt = 1;
                    d.sh  = {1'b1, q.sh[FRAME_BITS-1:1]};
                    if (q.bits == 4'(FRAME_BITS-1)) d.st = TX_IDLE;
                    else                            d.bits = q.bits + 4'd1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= TX_IDLE;
            q.sh   <= '1;
            q.cnt  <= '0;
            q.bits <= '0;
        end else begin
            q <= d;
        end
    end

    assign txd      = q.sh[0];
    assign tx_ready = (q.st == TX_IDLE);

    AST_TX_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TX_IDLE) |-> txd); // R1
    AST_TX_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TX_SHIFT && $past(q.st) == TX_IDLE) |-> !txd); // R1
endmodule

// File: rtl/uab_fifo.sv
`timescale 1ns/1ps
module uab_fifo #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_en,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    input  logic          ovf_clr,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] count,
    output logic          overflow
);
    localparam logic [CW-1:0] DEPTH_V = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_P  = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_reg_t;

    fifo_reg_t  q, d;
    logic [7:0] mem [DEPTH];
    logic       full, do_push, do_pop;

    assign full    = buf_en ? (q.cnt >= DEPTH_V) : (q.cnt != '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & (q.cnt != '0);

    always_comb begin
        d = q;
        if (do_push) d.wr = (q.wr == LAST_P) ? '0 : q.wr + 1'b1;
        if (do_pop)  d.rd = (q.rd == LAST_P) ? '0 : q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
        if (ovf_clr)     d.ovf = 1'b0;
        if (push & full) d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wr] <= push_data;
    end

    assign rd_data  = mem[q.rd];
    assign count    = q.cnt;
    assign overflow = q.ovf;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_V); // R6
    AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow); // R6
    AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_en && count <= CW'(1)) |=> count <= CW'(1)); // R7
endmodule

// File: rtl/uab_top.sv
`timescale 1ns/1ps
module uab_top #(
    parameter int DIV_W      = 18,
    parameter int MIN_DIV    = 8,
    parameter int RST_DIV    = 100,
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    output logic             txd,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    input  logic             rx_pop,
    output logic [CNT_W-1:0] rx_count,
    output logic             rx_overflow,
    input  logic             ovf_clr,
    input  logic             buf_en,
    output logic             frame_err,
    input  logic             div_load,
    input  logic [DIV_W-1:0] div_value,
    output logic [DIV_W-1:0] baud_div,
    input  logic             abaud_start,
    output logic             abaud_locked
);
    logic       rx_push;
    logic [7:0] rx_byte;

    uab_rx #(
        .DIV_W  (DIV_W),
        .MIN_DIV(MIN_DIV),
        .RST_DIV(RST_DIV)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd        (rxd),
        .div_load   (div_load),
        .div_value  (div_value),
        .abaud_start(abaud_start),
        .baud_div   (baud_div),
        .locked     (abaud_locked),
        .push       (rx_push),
        .push_data  (rx_byte),
        .frame_err  (frame_err)
    );

    uab_tx #(.DIV_W(DIV_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .baud_div(baud_div),
        .tx_valid(tx_valid),
        .tx_data (tx_data),
        .tx_ready(tx_ready),
        .txd     (txd)
    );

    uab_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .buf_en   (buf_en),
        .push     (rx_push),
        .push_data(rx_byte),
        .pop      (rx_pop),
        .ovf_clr  (ovf_clr),
        .rd_data  (rx_data),
        .count    (rx_count),
        .overflow (rx_overflow)
    );

    assign rx_valid = (rx_count != '0);
endmodule

// File: tb/uab_top_test.sv
`timescale 1ns/1ps
module uab_top_test;
    localparam int DIV_W = 18;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic txd;
    logic tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic tx_ready, rx_valid, rx_overflow, frame_err, abaud_locked;
    logic [7:0] rx_data;
    logic rx_pop = 1'b0, ovf_clr = 1'b0, buf_en = 1'b1;
    logic div_load = 1'b0, abaud_start = 1'b0;
    logic [DIV_W-1:0] div_value = '0;
    logic [DIV_W-1:0] baud_div;
    logic [4:0] rx_count;

    always #2.5 clk = ~clk;

    uab_top uut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop),
        .rx_count(rx_count), .rx_overflow(rx_overflow), .ovf_clr(ovf_clr),
        .buf_en(buf_en), .frame_err(frame_err), .div_load(div_load),
        .div_value(div_value), .baud_div(baud_div),
        .abaud_start(abaud_start), .abaud_locked(abaud_locked)
    );

    int n_chk = 0;
    int n_bad = 0;
    int fe_cnt = 0;
    bit finished = 0;
    logic [7:0] mq[$];
    int cap = DEPTH;
    logic [7:0] cap_byte;
    logic cap_start, cap_stop;
    logic ready_seen;

    always @(negedge clk) if (frame_err) fe_cnt++;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int model_push(input logic [7:0] b);
        if (mq.size() < cap) begin
            mq.push_back(b);
            return 0;
        end
        return 1;
    endfunction

    task automatic rx_send(input logic [7:0] b, input int div, input logic stop_bit);
        rxd = 1'b0;
        tick(div);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            tick(div);
        end
        rxd = stop_bit;
        tick(div);
        rxd = 1'b1;
        tick(stop_bit ? 4 : div);
    endtask

    task automatic tx_launch(input logic [7:0] b);
        tx_valid = 1'b1;
        tx_data  = b;
        tick(1);
        tx_valid   = 1'b0;
        ready_seen = tx_ready;
    endtask

    task automatic tx_capture(input int div);
        int guard = 0;
        while (txd === 1'b1 && guard < 100) begin
            tick(1);
            guard++;
        end
        tick(div / 2);
        cap_start = txd;
        for (int i = 0; i < 8; i++) begin
            tick(div);
            cap_byte[i] = txd;
        end
        tick(div);
        cap_stop = txd;
        tick(div);
    endtask

    task automatic tx_frame(input logic [7:0] b, input int div, input string req);
        fork
            tx_launch(b);
            tx_capture(div);
        join
        chk(req, "tx start bit", cap_start, 0);
        chk(req, "tx data", cap_byte, b);
        chk(req, "tx stop bit", cap_stop, 1);
        chk(req, "tx_ready low while busy", ready_seen, 0);
        chk(req, "tx_ready after frame", tx_ready, 1);
    endtask

    task automatic drain(input string req);
        while (mq.size() > 0) begin
            logic [7:0] e;
            e = mq.pop_front();
            chk(req, "rx_valid", rx_valid, 1);
            chk(req, "rx_data", rx_data, e);
            rx_pop = 1'b1;
            tick(1);
            rx_pop = 1'b0;
        end
        chk(req, "rx_count after drain", rx_count, 0);
    endtask

    task automatic load_div(input int v);
        div_value = DIV_W'(v);
        div_load  = 1'b1;
        tick(1);
        div_load = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [7:0] b, b2;
        int fe0, dummy;
        void'($urandom(32'd20240611));
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // reset state
        chk("R1", "txd idle", txd, 1);
        chk("R1", "tx_ready idle", tx_ready, 1);
        chk("R10", "rx_count reset", rx_count, 0);
        chk("R2", "rx_valid reset", rx_valid, 0);
        chk("R8", "reset divisor", baud_div, 100);
        chk("R9", "locked reset", abaud_locked, 0);
        chk("R6", "overflow reset", rx_overflow, 0);

        // direct divisor load and floor
        load_div(3);
        chk("R8", "divisor floor", baud_div, 8);
        load_div(16);
        chk("R8", "divisor load", baud_div, 16);

        // transmit: directed edge values then random
        tx_frame(8'h00, 16, "R1");
        tx_frame(8'hFF, 16, "R1");
        for (int i = 0; i < 3; i++) tx_frame(8'($urandom), 16, "R1");

        // receive random bytes
        for (int i = 0; i < 6; i++) begin
            b = 8'($urandom);
            dummy = model_push(b);
            rx_send(b, 16, 1'b1);
        end
        chk("R10", "rx_count after six", rx_count, 6);
        drain("R2");

        // full duplex
        b  = 8'($urandom);
        b2 = 8'($urandom);
        fork
            rx_send(b, 16, 1'b1);
            tx_frame(b2, 16, "R3");
        join
        dummy = model_push(b);
        drain("R3");

        // short glitch rejected
        fe0 = fe_cnt;
        rxd = 1'b0;
        tick(4);
        rxd = 1'b1;
        tick(48);
        chk("R4", "glitch not stored", rx_count, 0);
        chk("R4", "glitch no frame error", fe_cnt, fe0);
        b = 8'hA6;
        dummy = model_push(b);
        rx_send(b, 16, 1'b1);
        drain("R4");

        // framing error
        fe0 = fe_cnt;
        rx_send(8'h3C, 16, 1'b0);
        chk("R5", "frame_err pulses", fe_cnt, fe0 + 1);
        chk("R5", "bad frame not stored", rx_count, 0);

        // empty pop
        rx_pop = 1'b1;
        tick(1);
        rx_pop = 1'b0;
        tick(1);
        chk("R10", "pop on empty count", rx_count, 0);
        chk("R10", "pop on empty valid", rx_valid, 0);

        // overflow in buffered mode
        for (int i = 0; i < DEPTH + 1; i++) begin
            b = 8'($urandom);
            dummy = model_push(b);
            rx_send(b, 16, 1'b1);
        end
        chk("R6", "queue full count", rx_count, DEPTH);
        chk("R6", "overflow set", rx_overflow, 1);
        drain("R6");
        chk("R6", "overflow sticky", rx_overflow, 1);
        ovf_clr = 1'b1;
        tick(1);
        ovf_clr = 1'b0;
        chk("R6", "overflow cleared", rx_overflow, 0);

        // single-slot mode
        buf_en = 1'b0;
        cap = 1;
        for (int i = 0; i < 2; i++) begin
            b = 8'($urandom);
            dummy = model_push(b);
            rx_send(b, 16, 1'b1);
        end
        chk("R7", "single slot count", rx_count, 1);
        chk("R7", "single slot overflow", rx_overflow, 1);
        drain("R7");
        buf_en = 1'b1;
        cap = DEPTH;
        ovf_clr = 1'b1;
        tick(1);
        ovf_clr = 1'b0;

        // auto-baud at 40 cycles per bit
        abaud_start = 1'b1;
        tick(1);
        abaud_start = 1'b0;
        chk("R9", "lock cleared", abaud_locked, 0);
        rx_send(8'h55, 40, 1'b1);
        chk("R9", "locked", abaud_locked, 1);
        chk("R9", "measured divisor", baud_div, 40);
        chk("R9", "sync char not stored", rx_count, 0);
        for (int i = 0; i < 3; i++) begin
            b = 8'($urandom);
            dummy = model_push(b);
            rx_send(b, 40, 1'b1);
        end
        drain("R9");
        tx_frame(8'($urandom), 40, "R9");

        // auto-baud at a slower rate
        abaud_start = 1'b1;
        tick(1);
        abaud_start = 1'b0;
        rx_send(8'h55, 213, 1'b1);
        chk("R9", "measured slow divisor", baud_div, 213);
        chk("R9", "locked slow", abaud_locked, 1);
        b = 8'($urandom);
        dummy = model_push(b);
        rx_send(b, 213, 1'b1);
        drain("R9");

        // direct load drops lock
        load_div(16);
        chk("R8", "load clears lock", abaud_locked, 0);
        chk("R8", "reload divisor", baud_div, 16);

        finish_up();
    end
endmodule